// File: doc/BRIEF.md
# Paged Address Translator with Status Tracking

This block maps a 16-bit logical address onto a physical address through a sixteen-entry page table kept in flip-flops. The four high address bits select an entry. The entry supplies a 4-bit frame number, and the twelve low bits pass through unchanged as the offset inside the frame. Each entry also holds a residency flag, three permission flags (read, write, execute) and two status flags: referenced and modified. Software loads entries one at a time through a table-write port.

A request is answered one clock later. The answer is either a physical address or a fault with a cause code. The block raises separate faults for a page that is not resident and for an access that its permissions forbid. When a translation succeeds, the block updates the entry's status flags: any successful access marks the page referenced, and a successful write also marks it modified. Each response also reports the status flags as they stood before that access, so software can see them without a separate read path.

Servicing a fault, moving pages and choosing a victim are left to software. The block only reports the fault and the page that caused it.

Top module: `pt_mmu`

## Requirements
- R1: A successful response sets `rsp_paddr` to the frame number of entry `req_addr[15:12]` in bits 15:12 and to `req_addr[11:0]` unchanged in bits 11:0.
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R3: A request to an entry whose present flag is 0 gives `rsp_fault`=1, `rsp_cause`=1 and `rsp_paddr`=0.
- R4: Access codes are 0 read, 1 write and 2 execute. These codes require permission bits 0, 1 and 2 of the entry's `tw_perm` value. Code 3 is always refused. A refused access to a present page gives `rsp_fault`=1, `rsp_cause`=2 and `rsp_paddr`=0. An absent page reports cause 1 even if its permissions would also refuse the access. A response without a fault has `rsp_cause`=0.
- R5: A successful translation sets the entry's referenced flag.
- R6: A successful translation with access code 1 (write) sets the entry's modified flag. Other access codes leave it unchanged.
- R7: A request that faults changes neither the referenced flag nor the modified flag of any entry.
- R8: A table write with `tw_en`=1 loads the frame, present flag and permissions of entry `tw_page` and clears its referenced and modified flags. It takes effect for requests from the next cycle on. If a request in the same cycle would update that entry's status, the write wins.
- R9: Reset clears every entry, so all requests fault with cause 1 until entries are loaded. While reset is active, `rsp_valid` is 0.
- R10: Every response reports the request's page number on `rsp_page`. It also reports the entry's referenced and modified flags on `rsp_ref` and `rsp_mod` as they stood before that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 16 | Logical address |
| req_acc | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 16 | Physical address; 0 when the request faults |
| rsp_fault | output | 1 | The request faulted |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_page | output | 4 | Page number of the request |
| rsp_ref | output | 1 | Referenced flag of the entry before this access |
| rsp_mod | output | 1 | Modified flag of the entry before this access |
| tw_en | input | 1 | Table-write strobe |
| tw_page | input | 4 | Entry to load |
| tw_frame | input | 4 | Frame number to load |
| tw_present | input | 1 | Present flag to load |
| tw_perm | input | 3 | Permissions to load: bit 0 read, bit 1 write, bit 2 execute |

## Verification
The first requests after reset sweep all sixteen pages. They show that every entry starts absent and that the residency fault works on its own. Directed sequences then set up entries with single permission bits and send each access code to them. This separates protection faults from residency faults and from the reserved code. Repeated access to the same page shows how the referenced and modified flags build up, and a request to a page in the same cycle as a write to that page shows that the write wins. A long seeded random mix of requests, writes and idle cycles then exercises address pass-through, back-to-back responses and the interaction between status updates and reloads across all pages, compared against a reference model kept in the bench.

// File: rtl/pt_mmu_pkg.sv
package pt_mmu_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_PROT   = 2'd2
  } cause_e;

  localparam int PERM_W = 3;
endpackage

// File: rtl/pt_mmu_table.sv
module pt_mmu_table
  import pt_mmu_pkg::*;
#(
  parameter int PAGE_W  = 4,
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PAGE_W-1:0]  rd_page,
  output logic [FRAME_W-1:0] rd_frame,
  output logic               rd_present,
  output logic [PERM_W-1:0]  rd_perm,
  output logic               rd_ref,
  output logic               rd_mod,
  input  logic               upd_en,
  input  logic [PAGE_W-1:0]  upd_page,
  input  logic               upd_mod,
  input  logic               tw_en,
  input  logic [PAGE_W-1:0]  tw_page,
  input  logic [FRAME_W-1:0] tw_frame,
  input  logic               tw_present,
  input  logic [PERM_W-1:0]  tw_perm
);
  localparam int NPAGE = 1 << PAGE_W;

  logic [NPAGE-1:0][FRAME_W-1:0] frame_q;
  logic [NPAGE-1:0][PERM_W-1:0]  perm_q;
  logic [NPAGE-1:0]              pres_q;
  logic [NPAGE-1:0]              ref_q;
  logic [NPAGE-1:0]              mod_q;

  for (genvar i = 0; i < NPAGE; i++) begin : g_ent
    logic hit_tw, hit_up;
    assign hit_tw = tw_en && (tw_page == PAGE_W'(i));
    assign hit_up = upd_en && (upd_page == PAGE_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        frame_q[i] <= '0;
        perm_q[i]  <= '0;
        pres_q[i]  <= 1'b0;
        ref_q[i]   <= 1'b0;
        mod_q[i]   <= 1'b0;
      end else if (hit_tw) begin
        frame_q[i] <= tw_frame;
        perm_q[i]  <= tw_perm;
        pres_q[i]  <= tw_present;
        ref_q[i]   <= 1'b0;
        mod_q[i]   <= 1'b0;
      end else if (hit_up) begin
        ref_q[i] <= 1'b1;
        if (upd_mod) mod_q[i] <= 1'b1;
      end
    end

    // R5 R7: without a reload, status flags never drop
    assert_ref_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      (ref_q[i] && !hit_tw) |=> ref_q[i]);
    assert_mod_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (mod_q[i] && !hit_tw) |=> mod_q[i]);
  end

  assign rd_frame   = frame_q[rd_page];
  assign rd_present = pres_q[rd_page];
  assign rd_perm    = perm_q[rd_page];
  assign rd_ref     = ref_q[rd_page];
  assign rd_mod     = mod_q[rd_page];

  assert_tw_load_R8: assert property (@(posedge clk) disable iff (rst)
    tw_en |=> (pres_q[$past(tw_page)] == $past(tw_present)) &&
              (frame_q[$past(tw_page)] == $past(tw_frame)) &&
              !ref_q[$past(tw_page)] && !mod_q[$past(tw_page)]);

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (pres_q == '0));
endmodule

// File: rtl/pt_mmu_check.sv
module pt_mmu_check
  import pt_mmu_pkg::*;
(
  input  logic              present,
  input  logic [PERM_W-1:0] perm,
  input  logic [1:0]        acc,
  output logic              ok,
  output logic [1:0]        cause
);
  logic allowed;

  always_comb begin
    unique case (acc_e'(acc))
      ACC_READ:  allowed = perm[0];
      ACC_WRITE: allowed = perm[1];
      ACC_EXEC:  allowed = perm[2];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!present)      cause = CAUSE_ABSENT;
    else if (!allowed) cause = CAUSE_PROT;
    else               cause = CAUSE_NONE;
  end

  assign ok = (cause == CAUSE_NONE);
endmodule

// File: rtl/pt_mmu_resp.sv
module pt_mmu_resp #(
  parameter int PAGE_W = 4,
  parameter int PA_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_ok,
  input  logic [1:0]        in_cause,
  input  logic [PA_W-1:0]   in_paddr,
  input  logic [PAGE_W-1:0] in_page,
  input  logic              in_ref,
  input  logic              in_mod,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  output logic [PAGE_W-1:0] rsp_page,
  output logic              rsp_ref,
  output logic              rsp_mod
);
  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
      rsp_page  <= '0;
      rsp_ref   <= 1'b0;
      rsp_mod   <= 1'b0;
    end else begin
      rsp_valid <= 1'b1;
      rsp_paddr <= in_ok ? in_paddr : '0;
      rsp_fault <= !in_ok;
      rsp_cause <= in_cause;
      rsp_page  <= in_page;
      rsp_ref   <= in_ref;
      rsp_mod   <= in_mod;
    end
  end

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> rsp_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !rsp_valid && !rsp_fault);
  assert_fault_has_cause_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_cause != 2'd0) && (rsp_paddr == '0));
  assert_ok_no_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'd0));
endmodule

// File: rtl/pt_mmu.sv
module pt_mmu
  import pt_mmu_pkg::*;
#(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 4,
  localparam int PAGE_W = VA_W - OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_addr,
  input  logic [1:0]         req_acc,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               rsp_fault,
  output logic [1:0]         rsp_cause,
  output logic [PAGE_W-1:0]  rsp_page,
  output logic               rsp_ref,
  output logic               rsp_mod,
  input  logic               tw_en,
  input  logic [PAGE_W-1:0]  tw_page,
  input  logic [FRAME_W-1:0] tw_frame,
  input  logic               tw_present,
  input  logic [2:0]         tw_perm
);
  logic [PAGE_W-1:0]  page;
  logic [OFF_W-1:0]   offset;
  logic [FRAME_W-1:0] ent_frame;
  logic               ent_pres, ent_ref, ent_mod;
  logic [PERM_W-1:0]  ent_perm;
  logic               acc_ok;
  logic [1:0]         acc_cause;
  logic               upd_en;

  assign page   = req_addr[VA_W-1:OFF_W];
  assign offset = req_addr[OFF_W-1:0];
  assign upd_en = req_valid && acc_ok;

  pt_mmu_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .rd_page    (page),
    .rd_frame   (ent_frame),
    .rd_present (ent_pres),
    .rd_perm    (ent_perm),
    .rd_ref     (ent_ref),
    .rd_mod     (ent_mod),
    .upd_en     (upd_en),
    .upd_page   (page),
    .upd_mod    (req_acc == ACC_WRITE),
    .tw_en      (tw_en),
    .tw_page    (tw_page),
    .tw_frame   (tw_frame),
    .tw_present (tw_present),
    .tw_perm    (tw_perm)
  );

  pt_mmu_check u_check (
    .present (ent_pres),
    .perm    (ent_perm),
    .acc     (req_acc),
    .ok      (acc_ok),
    .cause   (acc_cause)
  );

  pt_mmu_resp #(.PAGE_W(PAGE_W), .PA_W(PA_W)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_ok     (acc_ok),
    .in_cause  (acc_cause),
    .in_paddr  ({ent_frame, offset}),
    .in_page   (page),
    .in_ref    (ent_ref),
    .in_mod    (ent_mod),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_page  (rsp_page),
    .rsp_ref   (rsp_ref),
    .rsp_mod   (rsp_mod)
  );

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && acc_ok) |=> rsp_paddr[OFF_W-1:0] == $past(offset));
  assert_page_report_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_page == $past(page));
  assert_absent_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ent_pres) |=> rsp_fault && (rsp_cause == 2'd1));
endmodule

// File: tb/pt_mmu_tb.sv
`timescale 1ns/1ps
module pt_mmu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid, rsp_fault, rsp_ref, rsp_mod;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_cause;
  logic [3:0]  rsp_page;
  logic        tw_en = 1'b0;
  logic [3:0]  tw_page = '0, tw_frame = '0;
  logic        tw_present = 1'b0;
  logic [2:0]  tw_perm = '0;

  int unsigned n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [3:0] m_frame [16];
  logic [2:0] m_perm  [16];
  logic       m_pres  [16];
  logic       m_ref   [16];
  logic       m_mod   [16];

  always #2.5 clk = ~clk;

  pt_mmu u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_page(rsp_page),
    .rsp_ref(rsp_ref), .rsp_mod(rsp_mod), .tw_en(tw_en), .tw_page(tw_page),
    .tw_frame(tw_frame), .tw_present(tw_present), .tw_perm(tw_perm)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [1:0] exp_cause(input logic [3:0] pg, input logic [1:0] acc);
    logic allowed;
    if (!m_pres[pg]) return 2'd1;
    case (acc)
      2'd0: allowed = m_perm[pg][0];
      2'd1: allowed = m_perm[pg][1];
      2'd2: allowed = m_perm[pg][2];
      default: allowed = 1'b0;
    endcase
    return allowed ? 2'd0 : 2'd2;
  endfunction

  task automatic step(input bit rv, input logic [15:0] a, input logic [1:0] acc,
                      input bit we, input logic [3:0] wp, input logic [3:0] wf,
                      input bit wpres, input logic [2:0] wperm, input string tag);
    logic [3:0]  pg;
    logic [1:0]  e_cause;
    logic [15:0] e_paddr;
    logic        e_ref, e_mod;
    @(negedge clk);
    req_valid = rv; req_addr = a; req_acc = acc;
    tw_en = we; tw_page = wp; tw_frame = wf; tw_present = wpres; tw_perm = wperm;
    pg      = a[15:12];
    e_cause = exp_cause(pg, acc);
    e_paddr = (e_cause == 2'd0) ? {m_frame[pg], a[11:0]} : 16'h0;
    e_ref   = m_ref[pg];
    e_mod   = m_mod[pg];
    @(posedge clk);
    #1;
    if (rv && e_cause == 2'd0) begin
      m_ref[pg] = 1'b1;
      if (acc == 2'd1) m_mod[pg] = 1'b1;
    end
    if (we) begin
      m_frame[wp] = wf; m_pres[wp] = wpres; m_perm[wp] = wperm;
      m_ref[wp] = 1'b0; m_mod[wp] = 1'b0;
    end
    chk({"R2 valid ", tag}, 32'(rsp_valid), 32'(rv));
    if (rv) begin
      chk({"R1 paddr ", tag}, 32'(rsp_paddr), 32'(e_paddr));
      chk({"R3 R4 fault ", tag}, 32'(rsp_fault), 32'(e_cause != 2'd0));
      chk({"R3 R4 cause ", tag}, 32'(rsp_cause), 32'(e_cause));
      chk({"R10 page ", tag}, 32'(rsp_page), 32'(pg));
      chk({"R5 R7 R10 ref ", tag}, 32'(rsp_ref), 32'(e_ref));
      chk({"R6 R7 R10 mod ", tag}, 32'(rsp_mod), 32'(e_mod));
    end
  endtask

  task automatic rq(input logic [15:0] a, input logic [1:0] acc, input string tag);
    step(1'b1, a, acc, 1'b0, 4'h0, 4'h0, 1'b0, 3'b000, tag);
  endtask

  task automatic ld(input logic [3:0] p, input logic [3:0] f, input bit pr,
                    input logic [2:0] pm, input string tag);
    step(1'b0, 16'h0, 2'd0, 1'b1, p, f, pr, pm, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_frame[i] = '0; m_perm[i] = '0; m_pres[i] = 0; m_ref[i] = 0; m_mod[i] = 0;
    end
    void'($urandom(32'h5eed_0042));
    req_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 valid held low in reset", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    req_valid = 1'b0;

    // R9: all pages absent after reset
    for (int p = 0; p < 16; p++) rq({p[3:0], 12'h5A5}, 2'd0, "R9 sweep");

    // R1 R8: load and translate, offset extremes
    ld(4'h3, 4'hB, 1'b1, 3'b111, "R8 load");
    rq(16'h3FFF, 2'd0, "R1 top offset");
    rq(16'h3000, 2'd2, "R1 R5 second access sees ref");
    rq(16'h3123, 2'd1, "R6 write");
    rq(16'h3123, 2'd0, "R6 mod visible");

    // R4: single permission entries
    ld(4'h5, 4'h2, 1'b1, 3'b001, "R8 read only");
    rq(16'h5010, 2'd1, "R4 write denied");
    rq(16'h5010, 2'd2, "R4 exec denied");
    rq(16'h5010, 2'd3, "R4 reserved code");
    rq(16'h5010, 2'd0, "R7 no status after faults");
    ld(4'h6, 4'h9, 1'b1, 3'b100, "R8 exec only");
    rq(16'h6777, 2'd0, "R4 read denied");
    rq(16'h6777, 2'd2, "R4 exec allowed");
    ld(4'h7, 4'h1, 1'b0, 3'b000, "R8 absent no perms");
    rq(16'h7000, 2'd3, "R4 absent precedence");

    // R8: same-cycle write beats status update
    step(1'b1, 16'h3444, 2'd1, 1'b1, 4'h3, 4'hC, 1'b1, 3'b011, "R8 collide");
    rq(16'h3444, 2'd0, "R8 status cleared after collision");
    // R8: reload takes effect next cycle, request sees old entry
    step(1'b1, 16'h5ABC, 2'd0, 1'b1, 4'h5, 4'h4, 1'b0, 3'b111, "R8 old entry used");
    rq(16'h5ABC, 2'd0, "R3 after unload");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 4) != 0, 16'($urandom), 2'($urandom), ($urandom % 8) == 0,
           4'($urandom), 4'($urandom), ($urandom % 4) != 0, 3'($urandom), "random");
    end

    step(1'b0, 16'h0, 2'd0, 1'b0, 4'h0, 4'h0, 1'b0, 3'b000, "R2 idle");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule